// File: doc/BRIEF.md
# Serial Control and Diagnosis Port for a Twelve-Switch Driver

This block is the logic-side serial slave of a driver with six high-side and six low-side power switches. A host selects it with an active-low chip select and clocks a 16-bit word in, least significant bit first. At the same time it clocks out a 16-bit status word in the same bit order. When the host releases chip select after exactly sixteen clocks, the received word becomes the active control word. That word carries the twelve switch enables and three protection enables. A frame of any other length is discarded, and the control word in force is kept.

Serial clock, data and select come from the host as asynchronous pins. Each passes through a two-flop synchroniser into the system clock, and edges are detected in that domain. Fault flags from the analog side are sticky: they are held until a committed control word with its clear bit set. The status word is captured when chip select falls, so that frame still reports the flags it clears. Power-on reset or a low inhibit input empties all stored control and status state. While inhibit is low, every switch output is forced off and no frame is accepted. A supply fault on the switch supply only sets its status flag and leaves the control word as it was.

Top module: `spi_drv_ctrl`

## Requirements
- R1: After reset, all twelve switch enables and the three protection enables are 0, and the serial output enable `sdo_en_o` is 0.
- R2: A complete frame commits its word when chip select rises. Data-in bits are taken at serial clock falling edges, first bit = word bit 0. Word bits 1..12 drive `sw_en_o[0]..sw_en_o[11]` in the switch order low 1, high 1, low 2, high 2, up to high 6. Bit 13 drives `ocsd_en_o`, bit 14 drives `ulsd_en_o` and bit 15 drives `ovlo_en_o`. A 1 means on.
- R3: While a frame is in progress, the control outputs keep the previously committed values.
- R4: If chip select rises after any number of falling clock edges other than 16, the frame is dropped and the control outputs do not change.
- R5: Once chip select has fallen and before any serial clock edge, `sdo_en_o` is 1 and `sdo_o` shows status bit 0 (temperature prewarning).
- R6: Each serial clock rising edge that follows k falling edges in the frame puts status bit k on `sdo_o`. The status word is laid out as follows: bit 0 is temperature prewarning, bits 1..12 are the switch faults in the R2 order, bit 13 is overload, bit 14 is underload and bit 15 is supply fail. A 1 means failure.
- R7: While chip select is high, `sdo_en_o` is 0.
- R8: A fault flag input that is high for at least one system clock is held. It is reported in the next frame even if the input has since dropped.
- R9: A committed word with bit 0 set clears all held flags. The frame that carries that word still reports them, and the next frame reads 0 for flags no longer active.
- R10: While `inhibit_ni` is low, the control outputs are 0 and a chip-select fall does not enable `sdo_o`. After inhibit, held flags and the control word read as cleared.
- R11: A pulse on `supply_fail_i` leaves the control outputs unchanged and is reported as status bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| inhibit_ni | input | 1 | Active-low inhibit; clears state and forces outputs off |
| sclk_i | input | 1 | Serial clock from host (asynchronous) |
| sdi_i | input | 1 | Serial data in from host (asynchronous) |
| csn_i | input | 1 | Active-low chip select (asynchronous) |
| sdo_o | output | 1 | Serial data out |
| sdo_en_o | output | 1 | Output enable for the three-state data-out pad |
| temp_warn_i | input | 1 | Temperature prewarning flag |
| sw_fault_i | input | 12 | Per-switch fault flags, R2 order |
| overload_i | input | 1 | Overload flag |
| underload_i | input | 1 | Underload flag |
| supply_fail_i | input | 1 | Switch-supply under/overvoltage flag |
| sw_en_o | output | 12 | Switch enables, R2 order |
| ocsd_en_o | output | 1 | Overcurrent shutdown enable |
| ulsd_en_o | output | 1 | Underload shutdown enable |
| ovlo_en_o | output | 1 | Overvoltage lockout enable |

## Verification
The hardest case to reach from the ports is the clear bit. The frame that carries it must read out the flags it erases, and the effect only shows in the frame after. The bench raises each status flag alone for a few cycles and then drops it. It then runs a frame with the clear bit set and checks every outgoing bit against a one-hot expectation. A second frame must then read all zeros. Frames of 15 and 17 clocks, and a chip-select fall while inhibited, check that an unfinished frame or a locked-out frame leaves no trace.

// File: rtl/spi_drv_pkg.sv
package spi_drv_pkg;
  localparam int NUM_SW  = 12;
  localparam int FRAME_W = NUM_SW + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int IDX_W   = $clog2(FRAME_W);

  typedef struct packed {
    logic              ovlo;
    logic              ulsd;
    logic              ocsd;
    logic [NUM_SW-1:0] sw;
    logic              clr;
  } ctrl_word_t;

  typedef struct packed {
    logic              supply_fail;
    logic              underload;
    logic              overload;
    logic [NUM_SW-1:0] sw_flt;
    logic              temp_warn;
  } stat_word_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_drv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               sclk_s_i,
  input  logic               sdi_s_i,
  input  logic               csn_s_i,
  input  logic [FRAME_W-1:0] status_i,
  output logic               sdo_o,
  output logic               sdo_en_o,
  output logic               commit_o,
  output logic [FRAME_W-1:0] rx_word_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);

  logic               sclk_d, csn_d, active;
  logic [CNT_W-1:0]   rx_cnt;
  logic [IDX_W-1:0]   out_idx;
  logic [FRAME_W-1:0] rx_sh, snap;
  logic               sclk_rise, sclk_fall, csn_fall, csn_rise;

  assign sclk_rise = sclk_s_i & ~sclk_d;
  assign sclk_fall = ~sclk_s_i & sclk_d;
  assign csn_fall  = ~csn_s_i & csn_d;
  assign csn_rise  = csn_s_i & ~csn_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d   <= 1'b0;
      csn_d    <= 1'b1;
      active   <= 1'b0;
      rx_cnt   <= '0;
      out_idx  <= '0;
      rx_sh    <= '0;
      snap     <= '0;
      commit_o <= 1'b0;
    end else begin
      sclk_d   <= sclk_s_i;
      csn_d    <= csn_s_i;
      commit_o <= 1'b0;
      if (clr_i) begin
        active <= 1'b0;
        rx_cnt <= '0;
        rx_sh  <= '0;
      end else if (csn_fall) begin
        active  <= 1'b1;
        snap    <= status_i;
        rx_cnt  <= '0;
        out_idx <= '0;
      end else if (csn_rise) begin
        active <= 1'b0;
        if (active && rx_cnt == CNT_FULL) commit_o <= 1'b1;
      end else if (active) begin
        if (sclk_fall) begin
          rx_sh <= {sdi_s_i, rx_sh[FRAME_W-1:1]};
          if (rx_cnt != CNT_MAX) rx_cnt <= rx_cnt + 1'b1;
        end
        if (sclk_rise)
          out_idx <= (rx_cnt >= CNT_FULL) ? IDX_W'(FRAME_W - 1) : rx_cnt[IDX_W-1:0];
      end
    end
  end

  assign sdo_en_o  = active;
  assign sdo_o     = active ? snap[out_idx] : 1'b0;
  assign rx_word_o = rx_sh;

  p_hiz_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_s_i && csn_d) |-> !sdo_en_o);
  p_commit_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(rx_cnt) == CNT_FULL);
  p_first_bit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_fall && !clr_i) |=> (sdo_en_o && sdo_o == $past(status_i[0])));
endmodule

// File: rtl/spi_ctrl_reg.sv
module spi_ctrl_reg
  import spi_drv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       commit_i,
  input  ctrl_word_t word_i,
  output ctrl_word_t ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_o <= '0;
    else if (clr_i)    ctrl_o <= '0;
    else if (commit_i) ctrl_o <= word_i;
  end

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !clr_i) |=> ctrl_o == $past(ctrl_o));
  p_inhibit_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ctrl_o == '0);
endmodule

// File: rtl/spi_flag_latch.sv
module spi_flag_latch
  import spi_drv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               wipe_i,
  input  logic [FRAME_W-1:0] flags_i,
  output logic [FRAME_W-1:0] held_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              held_o <= '0;
    else if (clr_i || wipe_i) held_o <= '0;
    else                      held_o <= held_o | flags_i;
  end

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wipe_i && !clr_i) |=> ((held_o & $past(held_o)) == $past(held_o)));
  p_wipe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_i |=> held_o == '0);
endmodule

// File: rtl/spi_drv_ctrl.sv
module spi_drv_ctrl
  import spi_drv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inhibit_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              csn_i,
  output logic              sdo_o,
  output logic              sdo_en_o,
  input  logic              temp_warn_i,
  input  logic [NUM_SW-1:0] sw_fault_i,
  input  logic              overload_i,
  input  logic              underload_i,
  input  logic              supply_fail_i,
  output logic [NUM_SW-1:0] sw_en_o,
  output logic              ocsd_en_o,
  output logic              ulsd_en_o,
  output logic              ovlo_en_o
);
  logic               sclk_s, sdi_s, csn_s, clr, commit;
  logic [FRAME_W-1:0] rx_word, held, status;
  stat_word_t         live;
  ctrl_word_t         ctrl;

  assign clr = ~inhibit_ni;

  spi_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({csn_i, sdi_i, sclk_i}),
    .q_o   ({csn_s, sdi_s, sclk_s})
  );

  assign live = '{supply_fail: supply_fail_i, underload: underload_i,
                  overload: overload_i, sw_flt: sw_fault_i, temp_warn: temp_warn_i};

  spi_flag_latch u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .wipe_i (commit & rx_word[0]),
    .flags_i(live),
    .held_o (held)
  );

  assign status = held | live;

  spi_frame u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .sclk_s_i (sclk_s),
    .sdi_s_i  (sdi_s),
    .csn_s_i  (csn_s),
    .status_i (status),
    .sdo_o    (sdo_o),
    .sdo_en_o (sdo_en_o),
    .commit_o (commit),
    .rx_word_o(rx_word)
  );

  spi_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .commit_i(commit),
    .word_i  (ctrl_word_t'(rx_word)),
    .ctrl_o  (ctrl)
  );

  assign sw_en_o   = ctrl.sw & {NUM_SW{inhibit_ni}};
  assign ocsd_en_o = ctrl.ocsd & inhibit_ni;
  assign ulsd_en_o = ctrl.ulsd & inhibit_ni;
  assign ovlo_en_o = ctrl.ovlo & inhibit_ni;

  p_uv_keeps_ctrl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supply_fail_i && !commit && inhibit_ni) |=> ctrl == $past(ctrl));
endmodule

// File: tb/spi_drv_ctrl_tb.sv
module spi_drv_ctrl_tb;
  localparam int H = 6;

  logic clk = 0, rst_ni = 0, inhibit_ni = 1;
  logic sclk = 0, sdi = 0, csn = 1;
  logic [15:0] flags_v = '0;
  logic sdo, sdo_en, ocsd, ulsd, ovlo;
  logic [11:0] sw_en;
  logic [15:0] exp_ctrl = '0;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  spi_drv_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .inhibit_ni(inhibit_ni),
    .sclk_i(sclk), .sdi_i(sdi), .csn_i(csn),
    .sdo_o(sdo), .sdo_en_o(sdo_en),
    .temp_warn_i(flags_v[0]), .sw_fault_i(flags_v[12:1]),
    .overload_i(flags_v[13]), .underload_i(flags_v[14]), .supply_fail_i(flags_v[15]),
    .sw_en_o(sw_en), .ocsd_en_o(ocsd), .ulsd_en_o(ulsd), .ovlo_en_o(ovlo)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] outs();
    return {ovlo, ulsd, ocsd, sw_en, 1'b0};
  endfunction

  task automatic chk_ctrl(input string req, input logic [15:0] w);
    chk(req, {16'h0, outs()}, {16'h0, w & 16'hFFFE});
  endtask

  task automatic frame(input logic [15:0] tx, input int nbits, input logic [15:0] exp_stat);
    csn = 0;
    wait_cyc(H);
    chk("R5 enable", {31'h0, sdo_en}, 32'h1);
    chk("R5 bit0", {31'h0, sdo}, {31'h0, exp_stat[0]});
    for (int i = 0; i < nbits; i++) begin
      sclk = 1;
      sdi  = tx[i % 16];
      wait_cyc(H);
      if (i < 16) chk("R6 status bit", {16'h0, 8'(i), 7'h0, sdo}, {16'h0, 8'(i), 7'h0, exp_stat[i]});
      if (i == 10) chk_ctrl("R3 mid-frame", exp_ctrl);
      sclk = 0;
      wait_cyc(H);
    end
    csn = 1;
    wait_cyc(8);
    chk("R7 idle hiz", {31'h0, sdo_en}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(3);
    chk_ctrl("R1 reset ctrl", 16'h0);
    chk("R1 reset hiz", {31'h0, sdo_en}, 32'h0);
    rst_ni = 1;
    wait_cyc(3);
    chk("R7 idle after reset", {31'h0, sdo_en}, 32'h0);

    // R2: walking ones plus arithmetic patterns
    for (int k = 0; k < 36; k++) begin
      logic [15:0] w;
      w = (k < 16) ? (16'h1 << k) : 16'(k * 16'h1357 + 16'h00F0);
      frame(w, 16, 16'h0);
      exp_ctrl = w;
      chk_ctrl("R2 commit", exp_ctrl);
    end

    // R8/R9/R11: one flag at a time
    for (int k = 0; k < 16; k++) begin
      flags_v = 16'h1 << k;
      wait_cyc(3);
      flags_v = '0;
      wait_cyc(3);
      chk_ctrl("R11 ctrl kept on flag", exp_ctrl);
      frame(exp_ctrl | 16'h1, 16, 16'h1 << k);
      exp_ctrl = exp_ctrl | 16'h1;
      frame(exp_ctrl & 16'hFFFE, 16, 16'h0);
      exp_ctrl = exp_ctrl & 16'hFFFE;
      chk_ctrl("R9 ctrl after clear", exp_ctrl);
    end

    // R4: short and long frames dropped
    frame(16'hA5A4, 15, 16'h0);
    chk_ctrl("R4 short frame", exp_ctrl);
    frame(16'h5A5A, 17, 16'h0);
    chk_ctrl("R4 long frame", exp_ctrl);
    frame(16'h3C3C, 16, 16'h0);
    exp_ctrl = 16'h3C3C;
    chk_ctrl("R2 after drop", exp_ctrl);

    // R10: inhibit
    flags_v = 16'h8002;
    wait_cyc(3);
    flags_v = '0;
    inhibit_ni = 0;
    wait_cyc(3);
    chk_ctrl("R10 outputs off", 16'h0);
    csn = 0;
    wait_cyc(H);
    chk("R10 no select", {31'h0, sdo_en}, 32'h0);
    csn = 1;
    wait_cyc(H);
    inhibit_ni = 1;
    wait_cyc(3);
    exp_ctrl = 16'h0;
    chk_ctrl("R10 ctrl cleared", 16'h0);
    frame(16'h7FF0, 16, 16'h0);
    exp_ctrl = 16'h7FF0;
    chk_ctrl("R10 resume", exp_ctrl);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule